// File: doc/BRIEF.md
# Downstream Hub Port Register File

This block is the firmware-facing register set for the downstream ports of a hub, seven by default. A byte-wide bus uses a 3-bit address, separate write and read strobes, write data, and read data. The read data is combinational from the address.

Per-port access goes through a pointer register and a single data window. The pointer selects a port and a byte within it. An even pointer reaches that port's control byte, which the firmware writes and reads back. An odd pointer reaches the port's live status byte, which is read-only.

Flat registers hold the following:
- hub-level control bits and the host-resume flag
- sticky per-port activity bits, plus the frame-lock flag
- a snapshot of every port's D-/D+ levels, taken at the EOF2 strobe (10 clocks before end of frame)
- per-port power enables
- per-port interrupt enables

A single interrupt line is raised when an enabled port's status byte has changed and that byte has not yet been read.

Top module: `hub_port_regfile`

Register offsets on `bus_addr`: 0 pointer, 1 data window, 2 hub control, 3 activity, 4 line-state low, 5 line-state high, 6 power enable, 7 interrupt enable.

## Requirements
- R1: A pointer value i (written at offset 0, read back at offset 0 as a 4-bit value) selects port i>>1, counting from port 0. A write at offset 1 with an even pointer loads that port's control byte on `port_ctl[8p+7:8p]` and changes no other port. The control bits from bit 0 up are: power on, enable, reset, suspend, power good, reset-activity detect, drive resume, force SE0.
- R2: A read at offset 1 with an even pointer returns the selected port's control byte.
- R3: A read at offset 1 with an odd pointer returns `port_sts[8p+7:8p]` of the selected port. A write with an odd pointer changes no control byte.
- R4: Pointer values 14 and 15 select no port. Data writes through them are ignored and data reads return 0.
- R5: The activity register (offset 3) returns `frame_locked` in bit 0 and sticky per-port activity in bits 1..7, with port p in bit p+1. Reading the register clears the sticky bits. A pulse that arrives in the same cycle as the read survives the read.
- R6: On a clock with `eof2` high, the D-/D+ levels of every port are captured. Port p takes bit 2p (D-) and bit 2p+1 (D+) of a 16-bit image. Offset 4 returns image bits 7:0 and offset 5 returns bits 15:8, with unused top bits reading 0. The image holds its value between strobes.
- R7: Offset 6 holds one power-enable bit per port in bits 0..6, driven on `pwr_en`. Bit 7 drives `force_frame_lock`. All eight bits read back.
- R8: Offset 7 holds one interrupt-enable bit per port in bits 0..6, and bit 7 reads 0. `port_irq` is high while some enabled port has a pending status change. A change is pending when the port's status byte differed from its value in the previous clock. A read of that port's status byte clears it.
- R9: Offset 2 stores bits 0..5 and drives them on `hub_ctl`. Bit 6 always reads 0. Bit 7 reads the `host_resume` input, and writes to bit 7 have no effect.
- R10: After reset, all control bytes, power enables, interrupt enables, hub control bits and the pointer are 0, and `port_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears read-sensitive state) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| port_ctl | output | 56 | Control byte per port, port p at bits 8p+7:8p |
| port_sts | input | 56 | Live status byte per port |
| port_act | input | 7 | Activity pulse per port |
| frame_locked | input | 1 | Frame timer locked flag |
| eof2 | input | 1 | Line-state capture strobe |
| line_dm | input | 7 | D- level per port |
| line_dp | input | 7 | D+ level per port |
| pwr_en | output | 7 | Power enable per port |
| force_frame_lock | output | 1 | Forces frame lock |
| hub_ctl | output | 6 | Hub-level control bits |
| host_resume | input | 1 | Host resume flag, visible in hub control bit 7 |
| port_irq | output | 1 | Interrupt from enabled status changes |

## Verification
The bench sweeps all sixteen pointer values, writing a distinct byte through each one and checking both the whole `port_ctl` bus and the readback. This catches a design that decodes the port from the wrong pointer bits, lets odd or out-of-range pointers corrupt a control byte, or returns stale data for pointers 14 and 15.

It pulses activity in the same cycle as the clearing read. A design that gives the clear priority would lose that event.

It moves the line levels without a strobe. A design that samples continuously, or swaps D- and D+ within a pair, reads back the wrong image.

The interrupt sequence changes a disabled port's status before an enabled one, then clears the change by reading status. This exposes a missing mask and a clear aimed at the wrong port.

// File: rtl/hub_prf_pkg.sv
package hub_prf_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 4;

  typedef enum logic [2:0] {
    RA_INDEX    = 3'd0,
    RA_DATA     = 3'd1,
    RA_HUBCTL   = 3'd2,
    RA_ACTIVITY = 3'd3,
    RA_LINE_LO  = 3'd4,
    RA_LINE_HI  = 3'd5,
    RA_PWR_EN   = 3'd6,
    RA_IRQ_EN   = 3'd7
  } reg_addr_e;

  // port number addressed by a pointer value
  function automatic logic [2:0] ptr_port(logic [IDX_W-1:0] ptr);
    return ptr[IDX_W-1:1];
  endfunction

  // odd pointer means the status byte
  function automatic logic ptr_is_status(logic [IDX_W-1:0] ptr);
    return ptr[0];
  endfunction

  function automatic logic ptr_valid(logic [IDX_W-1:0] ptr, int nports);
    return int'(ptr[IDX_W-1:1]) < nports;
  endfunction
endpackage

// File: rtl/hub_prf_port_bank.sv
module hub_prf_port_bank #(
  parameter int N_PORTS = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_we,
  input  logic [2:0]           sel,
  input  logic [7:0]           wdata,
  input  logic                 sts_rd,
  input  logic [N_PORTS*8-1:0] sts_in,
  output logic [N_PORTS*8-1:0] ctl_out,
  output logic [N_PORTS-1:0]   chg
);
  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    logic [7:0] ctl_q;
    logic [7:0] sts_q;
    logic       hit;
    logic       moved;

    assign hit   = (sel == 3'(p));
    assign moved = (sts_in[p*8 +: 8] != sts_q);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl_q  <= '0;
        sts_q  <= '0;
        chg[p] <= 1'b0;
      end else begin
        if (ctl_we && hit) ctl_q <= wdata;
        sts_q <= sts_in[p*8 +: 8];
        // a new change wins over a clearing read in the same cycle
        if (moved)             chg[p] <= 1'b1;
        else if (sts_rd && hit) chg[p] <= 1'b0;
      end
    end

    assign ctl_out[p*8 +: 8] = ctl_q;
  end
endmodule

// File: rtl/hub_prf_activity.sv
module hub_prf_activity #(
  parameter int N_PORTS = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] act_in,
  input  logic               clr,
  output logic [N_PORTS-1:0] sticky
);
  always_ff @(posedge clk) begin
    if (!rst_n) sticky <= '0;
    else        sticky <= (sticky & ~{N_PORTS{clr}}) | act_in;
  end
endmodule

// File: rtl/hub_prf_line_sampler.sv
module hub_prf_line_sampler #(
  parameter int N_PORTS = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strobe,
  input  logic [N_PORTS-1:0]   dm,
  input  logic [N_PORTS-1:0]   dp,
  output logic [2*N_PORTS-1:0] image
);
  for (genvar p = 0; p < N_PORTS; p++) begin : g_pair
    always_ff @(posedge clk) begin
      if (!rst_n)      image[2*p +: 2] <= 2'b00;
      else if (strobe) image[2*p +: 2] <= {dp[p], dm[p]};
    end
  end
endmodule

// File: rtl/hub_port_regfile.sv
module hub_port_regfile
  import hub_prf_pkg::*;
#(
  parameter int N_PORTS = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  output logic [N_PORTS*8-1:0] port_ctl,
  input  logic [N_PORTS*8-1:0] port_sts,
  input  logic [N_PORTS-1:0]   port_act,
  input  logic                 frame_locked,
  input  logic                 eof2,
  input  logic [N_PORTS-1:0]   line_dm,
  input  logic [N_PORTS-1:0]   line_dp,
  output logic [N_PORTS-1:0]   pwr_en,
  output logic                 force_frame_lock,
  output logic [5:0]           hub_ctl,
  input  logic                 host_resume,
  output logic                 port_irq
);
  localparam int IMG_W = 2 * N_PORTS;

  logic [IDX_W-1:0]   idx_q;
  logic [5:0]         hubctl_q;
  logic [N_PORTS-1:0] pwr_q;
  logic               lock_q;
  logic [N_PORTS-1:0] irqen_q;

  logic [N_PORTS-1:0] act_sticky;
  logic [IMG_W-1:0]   line_img;
  logic [N_PORTS-1:0] chg;

  // named internal events
  logic       idx_ok;
  logic [2:0] sel_port;
  logic       ctl_wr_hit;
  logic       sts_rd_hit;
  logic       act_rd_hit;

  assign idx_ok     = ptr_valid(idx_q, N_PORTS);
  assign sel_port   = ptr_port(idx_q);
  assign ctl_wr_hit = bus_wr && (bus_addr == RA_DATA) && idx_ok && !ptr_is_status(idx_q);
  assign sts_rd_hit = bus_rd && (bus_addr == RA_DATA) && idx_ok && ptr_is_status(idx_q);
  assign act_rd_hit = bus_rd && (bus_addr == RA_ACTIVITY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      hubctl_q <= '0;
      pwr_q    <= '0;
      lock_q   <= 1'b0;
      irqen_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        RA_INDEX:  idx_q    <= bus_wdata[IDX_W-1:0];
        RA_HUBCTL: hubctl_q <= bus_wdata[5:0];
        RA_PWR_EN: begin
          pwr_q  <= bus_wdata[N_PORTS-1:0];
          lock_q <= bus_wdata[7];
        end
        RA_IRQ_EN: irqen_q  <= bus_wdata[N_PORTS-1:0];
        default: ;
      endcase
    end
  end

  hub_prf_port_bank #(.N_PORTS(N_PORTS)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_we (ctl_wr_hit),
    .sel    (sel_port),
    .wdata  (bus_wdata),
    .sts_rd (sts_rd_hit),
    .sts_in (port_sts),
    .ctl_out(port_ctl),
    .chg    (chg)
  );

  hub_prf_activity #(.N_PORTS(N_PORTS)) u_act (
    .clk   (clk),
    .rst_n (rst_n),
    .act_in(port_act),
    .clr   (act_rd_hit),
    .sticky(act_sticky)
  );

  hub_prf_line_sampler #(.N_PORTS(N_PORTS)) u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(eof2),
    .dm    (line_dm),
    .dp    (line_dp),
    .image (line_img)
  );

  logic [15:0] img_ext;
  logic [7:0]  act_ext;
  logic [7:0]  pwr_ext;
  logic [7:0]  irq_ext;
  logic [7:0]  win_data;

  always_comb begin
    img_ext = '0;
    img_ext[IMG_W-1:0] = line_img;
    act_ext = '0;
    act_ext[0] = frame_locked;
    act_ext[N_PORTS:1] = act_sticky;
    pwr_ext = '0;
    pwr_ext[N_PORTS-1:0] = pwr_q;
    pwr_ext[7] = lock_q;
    irq_ext = '0;
    irq_ext[N_PORTS-1:0] = irqen_q;
    win_data = '0;
    if (idx_ok) begin
      if (ptr_is_status(idx_q)) win_data = port_sts[sel_port*8 +: 8];
      else                      win_data = port_ctl[sel_port*8 +: 8];
    end
  end

  always_comb begin
    case (bus_addr)
      RA_INDEX:    bus_rdata = {4'b0, idx_q};
      RA_DATA:     bus_rdata = win_data;
      RA_HUBCTL:   bus_rdata = {host_resume, 1'b0, hubctl_q};
      RA_ACTIVITY: bus_rdata = act_ext;
      RA_LINE_LO:  bus_rdata = img_ext[7:0];
      RA_LINE_HI:  bus_rdata = img_ext[15:8];
      RA_PWR_EN:   bus_rdata = pwr_ext;
      default:     bus_rdata = irq_ext;
    endcase
  end

  assign pwr_en           = pwr_q;
  assign force_frame_lock = lock_q;
  assign hub_ctl          = hubctl_q;
  assign port_irq         = |(chg & irqen_q);
endmodule

// File: rtl/hub_port_regfile_chk.sv
module hub_port_regfile_chk #(
  parameter int N_PORTS = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           bus_addr,
  input logic [7:0]           bus_rdata,
  input logic [N_PORTS*8-1:0] port_ctl,
  input logic [N_PORTS-1:0]   port_act,
  input logic                 eof2,
  input logic                 host_resume,
  input logic                 port_irq,
  input logic [N_PORTS-1:0]   pwr_en,
  input logic [3:0]           idx_q,
  input logic [N_PORTS-1:0]   irqen_q,
  input logic                 ctl_wr_hit,
  input logic [N_PORTS-1:0]   act_sticky,
  input logic [2*N_PORTS-1:0] line_img
);
  localparam logic [7:0] HI_MASK = 8'((1 << (2 * N_PORTS - 8)) - 1);

  assert_ctl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr_hit |=> $stable(port_ctl));

  assert_empty_ptr_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd1 && int'(idx_q[3:1]) >= N_PORTS) |-> bus_rdata == 8'd0);

  assert_hubctl_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd2) |-> (bus_rdata[6] == 1'b0 && bus_rdata[7] == host_resume));

  assert_line_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !eof2 |=> $stable(line_img));

  assert_line_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd5) |-> (bus_rdata & ~HI_MASK) == 8'd0);

  assert_act_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_act != '0) |=> ((act_sticky & $past(port_act)) == $past(port_act)));

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    port_irq |-> (irqen_q != '0));

  assert_pwr_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd6) |-> bus_rdata[N_PORTS-1:0] == pwr_en);
endmodule

bind hub_port_regfile hub_port_regfile_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .port_ctl   (port_ctl),
  .port_act   (port_act),
  .eof2       (eof2),
  .host_resume(host_resume),
  .port_irq   (port_irq),
  .pwr_en     (pwr_en),
  .idx_q      (idx_q),
  .irqen_q    (irqen_q),
  .ctl_wr_hit (ctl_wr_hit),
  .act_sticky (act_sticky),
  .line_img   (line_img)
);

// File: tb/hub_port_regfile_tb.sv
module hub_port_regfile_tb;
  localparam int NP = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [NP*8-1:0] port_ctl;
  logic [NP*8-1:0] port_sts = '0;
  logic [NP-1:0] port_act = '0;
  logic frame_locked = 1'b0, eof2 = 1'b0;
  logic [NP-1:0] line_dm = '0, line_dp = '0;
  logic [NP-1:0] pwr_en;
  logic force_frame_lock;
  logic [5:0] hub_ctl;
  logic host_resume = 1'b0;
  logic port_irq;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hub_port_regfile #(.N_PORTS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_ctl(port_ctl), .port_sts(port_sts),
    .port_act(port_act), .frame_locked(frame_locked), .eof2(eof2), .line_dm(line_dm),
    .line_dp(line_dp), .pwr_en(pwr_en), .force_frame_lock(force_frame_lock),
    .hub_ctl(hub_ctl), .host_resume(host_resume), .port_irq(port_irq)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [7:0] sts_pat(int p);
    return 8'(8'hA0 ^ (p * 17));
  endfunction

  function automatic logic [7:0] ctl_pat(int i);
    return 8'(i * 37 + 5);
  endfunction

  initial begin
    logic [7:0] d;
    logic [7:0] model [NP];
    logic [NP*8-1:0] mvec;
    logic [15:0] img;
    for (int p = 0; p < NP; p++) begin
      port_sts[p*8 +: 8] = sts_pat(p);
      model[p] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    #1;
    check("R10 port_ctl", 64'(port_ctl), 64'd0);
    check("R10 pwr_en", 64'(pwr_en), 64'd0);
    check("R10 irq", 64'(port_irq), 64'd0);
    check("R10 hub_ctl", 64'(hub_ctl), 64'd0);
    rd(3'd0, d); check("R10 pointer", 64'(d), 64'd0);

    // R1 R2 R3 R4 pointer sweep
    for (int i = 0; i < 16; i++) begin
      wr(3'd0, 8'(i));
      rd(3'd0, d); check("R1 pointer readback", 64'(d), 64'(i));
      wr(3'd1, ctl_pat(i));
      if (i < 2 * NP && (i % 2) == 0) model[i / 2] = ctl_pat(i);
      for (int p = 0; p < NP; p++) mvec[p*8 +: 8] = model[p];
      check("R1 R3 R4 port_ctl after write", 64'(port_ctl), 64'(mvec));
      rd(3'd1, d);
      if (i >= 2 * NP)       check("R4 empty pointer read", 64'(d), 64'd0);
      else if (i % 2 == 0)   check("R2 control readback", 64'(d), 64'(model[i / 2]));
      else                   check("R3 status read", 64'(d), 64'(sts_pat(i / 2)));
    end

    // R5 activity
    frame_locked = 1'b1;
    @(negedge clk); port_act = 7'b1010010;
    @(negedge clk); port_act = '0;
    rd(3'd3, d); check("R5 sticky activity", 64'(d), 64'({7'b1010010, 1'b1}));
    rd(3'd3, d); check("R5 cleared by read", 64'(d), 64'h01);
    @(negedge clk); bus_addr = 3'd3; bus_rd = 1'b1; port_act = 7'b0000100;
    @(negedge clk); bus_rd = 1'b0; port_act = '0;
    rd(3'd3, d); check("R5 pulse during read survives", 64'(d), 64'({7'b0000100, 1'b1}));
    frame_locked = 1'b0;
    rd(3'd3, d); check("R5 frame lock live", 64'(d), 64'h00);

    // R6 line capture
    line_dm = 7'b1010101; line_dp = 7'b0110011;
    @(negedge clk); eof2 = 1'b1;
    @(negedge clk); eof2 = 1'b0;
    img = '0;
    for (int p = 0; p < NP; p++) begin
      img[2*p] = line_dm[p]; img[2*p+1] = line_dp[p];
    end
    line_dm = 7'b0101010; line_dp = 7'b1001100;
    rd(3'd4, d); check("R6 line low", 64'(d), 64'(img[7:0]));
    rd(3'd5, d); check("R6 line high", 64'(d), 64'(img[15:8]));
    @(negedge clk); eof2 = 1'b1;
    @(negedge clk); eof2 = 1'b0;
    img = '0;
    for (int p = 0; p < NP; p++) begin
      img[2*p] = line_dm[p]; img[2*p+1] = line_dp[p];
    end
    rd(3'd4, d); check("R6 line low second", 64'(d), 64'(img[7:0]));
    rd(3'd5, d); check("R6 line high second", 64'(d), 64'(img[15:8]));

    // R7 power enable
    wr(3'd6, 8'h9B);
    check("R7 pwr_en", 64'(pwr_en), 64'h1B);
    check("R7 force lock", 64'(force_frame_lock), 64'd1);
    rd(3'd6, d); check("R7 readback", 64'(d), 64'h9B);

    // R8 interrupt enables and changes
    wr(3'd7, 8'hFF);
    rd(3'd7, d); check("R8 irq enable readback", 64'(d), 64'h7F);
    check("R8 no pending change", 64'(port_irq), 64'd0);
    wr(3'd7, 8'h04);
    @(negedge clk); port_sts[1*8 +: 8] = 8'h3C;
    @(negedge clk);
    check("R8 masked port change", 64'(port_irq), 64'd0);
    port_sts[2*8 +: 8] = 8'h5A;
    @(negedge clk);
    check("R8 enabled port change", 64'(port_irq), 64'd1);
    wr(3'd0, 8'd5);
    rd(3'd1, d); check("R8 new status value", 64'(d), 64'h5A);
    check("R8 cleared by status read", 64'(port_irq), 64'd0);

    // R9 hub control
    wr(3'd2, 8'hFF);
    check("R9 hub_ctl out", 64'(hub_ctl), 64'h3F);
    rd(3'd2, d); check("R9 readback no resume", 64'(d), 64'h3F);
    host_resume = 1'b1;
    rd(3'd2, d); check("R9 readback with resume", 64'(d), 64'hBF);
    wr(3'd2, 8'h15);
    rd(3'd2, d); check("R9 partial write", 64'(d), 64'h95);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule